// File: doc/BRIEF.md
# Shared Memory Bus Arbiter with Reserved Slots

This block decides, once per memory cycle, which requester owns a memory bus that video hardware and the system share. Some cycles belong to a fixed schedule of display, refresh and similar fetches that are never contended. An upstream schedule generator flags these cycles, and the arbiter grants nobody in them. Every other cycle goes to the highest-ranked requester. The display coprocessor ranks first, then the block-copy engine, then the external DMA masters, and the CPU ranks last. Among the DMA masters, the lowest slot number wins.

A DMA master that wins the bus keeps it for its whole burst, until it drops its request. The only exception is a reserved cycle. The owner loses the bus for that cycle and gets it back afterwards, ahead of every other requester.

A second, simpler path arbitrates a private fast memory that only the CPU and the DMA masters can reach. On that path any DMA request beats the CPU. Both paths register their grants, so a grant reflects the requests sampled at the previous clock edge.

Top module: `shared_mem_arbiter`

## Requirements
- R1: If the reserved-slot input is high at a clock edge, `bus_gnt` is all zero in the following cycle, whatever is requested.
- R2: In a free cycle with no DMA burst in progress, a coprocessor request wins. `bus_gnt` bit 0 is set in the next cycle.
- R3: The block-copy engine (`bus_gnt` bit 1) wins over the DMA masters and the CPU, and it loses only to the coprocessor.
- R4: A DMA master wins over the CPU. Master k is granted on `bus_gnt` bit 2+k.
- R5: When several DMA masters request and none holds the bus, the master with the lowest index is granted.
- R6: The CPU (`bus_gnt` bit N_DMA+2) is granted only when no other requester asked in the sampled cycle.
- R7: Grants are registered. They follow the requests sampled at the previous edge, and at most one bit of `bus_gnt` is set.
- R8: `bus_idle` is high exactly when `bus_gnt` is zero.
- R9: A granted DMA master keeps the grant while its request stays high, even when the coprocessor or the block-copy engine asks.
- R10: If a reserved cycle interrupts a DMA burst, the same master is granted again in the first free cycle, provided it is still requesting.
- R11: On the fast-memory path, any DMA request beats the CPU. The lowest-index DMA master is granted on `fm_gnt` bit k, and the CPU on `fm_gnt` bit N_DMA.
- R12: While reset is asserted and right after it, both grant vectors are zero and `bus_idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsv_slot | input | 1 | Current cycle is reserved by the schedule |
| cop_req | input | 1 | Display coprocessor request |
| blt_req | input | 1 | Block-copy engine request |
| dma_req | input | N_DMA | External DMA master requests, index = slot |
| cpu_req | input | 1 | CPU request for the shared bus |
| fm_dma_req | input | N_DMA | DMA master requests for fast memory |
| fm_cpu_req | input | 1 | CPU request for fast memory |
| bus_gnt | output | N_DMA+3 | One-hot shared-bus grant |
| bus_idle | output | 1 | No shared-bus grant this cycle |
| fm_gnt | output | N_DMA+1 | One-hot fast-memory grant |

## Verification
Every grant, and `bus_idle`, is due exactly one cycle after the inputs that cause it. A request presented in cycle t is sampled at the following rising edge and shows on the outputs right after that edge. The bench therefore changes its inputs on the falling edge and reads the outputs 1 ns after the next rising edge, so each check sees the result of the inputs it has just applied. For the burst-hold and reserved-slot cases, the bench applies one cycle of stimulus at a time and checks the grant after every edge. This follows the owner through the interruption and back.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
  localparam int GNT_COP  = 0;
  localparam int GNT_BLT  = 1;
  localparam int GNT_DMA0 = 2;

  // isolate the lowest set bit of a vector
  function automatic logic [31:0] lowest_one(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction
endpackage

// File: rtl/dma_pick.sv
module dma_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] oh
);
  logic [31:0] wide;
  always_comb begin
    wide = '0;
    wide[N-1:0] = req;
  end
  logic [31:0] picked;
  assign picked = mem_arb_pkg::lowest_one(wide);
  assign oh = picked[N-1:0];
endmodule

// File: rtl/chip_arb.sv
module chip_arb #(
  parameter int N = 4,
  localparam int G = N + 3,
  localparam int CPU_BIT = N + 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rsv,
  input  logic         cop_req,
  input  logic         blt_req,
  input  logic [N-1:0] dma_req,
  input  logic         cpu_req,
  input  logic [N-1:0] dma_oh,
  output logic [G-1:0] gnt,
  output logic         idle,
  output logic         hold_live
);
  import mem_arb_pkg::*;
  logic [N-1:0] own_q, own_d;
  logic [G-1:0] gnt_d;

  assign hold_live = |(own_q & dma_req);

  always_comb begin
    gnt_d = '0;
    own_d = own_q & dma_req;
    if (rsv) begin
      gnt_d = '0;
    end else if (hold_live) begin
      gnt_d[GNT_DMA0 +: N] = own_q;
    end else if (cop_req) begin
      gnt_d[GNT_COP] = 1'b1;
    end else if (blt_req) begin
      gnt_d[GNT_BLT] = 1'b1;
    end else if (|dma_req) begin
      gnt_d[GNT_DMA0 +: N] = dma_oh;
      own_d = dma_oh;
    end else if (cpu_req) begin
      gnt_d[CPU_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt   <= '0;
      idle  <= 1'b1;
      own_q <= '0;
    end else begin
      gnt   <= gnt_d;
      idle  <= ~|gnt_d;
      own_q <= own_d;
    end
  end
endmodule

// File: rtl/fast_arb.sv
module fast_arb #(
  parameter int N = 4,
  localparam int G = N + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] dma_oh,
  input  logic         any_dma,
  input  logic         cpu_req,
  output logic [G-1:0] gnt
);
  logic [G-1:0] gnt_d;
  always_comb begin
    gnt_d = '0;
    if (any_dma) gnt_d[N-1:0] = dma_oh;
    else if (cpu_req) gnt_d[N] = 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt <= '0;
    else        gnt <= gnt_d;
  end
endmodule

// File: rtl/shared_mem_arbiter.sv
module shared_mem_arbiter #(
  parameter int N_DMA = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsv_slot,
  input  logic             cop_req,
  input  logic             blt_req,
  input  logic [N_DMA-1:0] dma_req,
  input  logic             cpu_req,
  input  logic [N_DMA-1:0] fm_dma_req,
  input  logic             fm_cpu_req,
  output logic [N_DMA+2:0] bus_gnt,
  output logic             bus_idle,
  output logic [N_DMA:0]   fm_gnt
);
  logic [N_DMA-1:0] chip_oh, fast_oh;
  logic hold_live;

  dma_pick #(.N(N_DMA)) u_pick_chip (.req(dma_req),    .oh(chip_oh));
  dma_pick #(.N(N_DMA)) u_pick_fast (.req(fm_dma_req), .oh(fast_oh));

  chip_arb #(.N(N_DMA)) u_chip (
    .clk(clk), .rst_n(rst_n), .rsv(rsv_slot), .cop_req(cop_req),
    .blt_req(blt_req), .dma_req(dma_req), .cpu_req(cpu_req),
    .dma_oh(chip_oh), .gnt(bus_gnt), .idle(bus_idle), .hold_live(hold_live)
  );

  fast_arb #(.N(N_DMA)) u_fast (
    .clk(clk), .rst_n(rst_n), .dma_oh(fast_oh), .any_dma(|fm_dma_req),
    .cpu_req(fm_cpu_req), .gnt(fm_gnt)
  );
endmodule

// File: rtl/shared_mem_arbiter_chk.sv
module shared_mem_arbiter_chk #(
  parameter int N_DMA = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rsv_slot,
  input logic             cop_req,
  input logic             blt_req,
  input logic [N_DMA-1:0] dma_req,
  input logic             cpu_req,
  input logic [N_DMA-1:0] fm_dma_req,
  input logic [N_DMA+2:0] bus_gnt,
  input logic             bus_idle,
  input logic [N_DMA:0]   fm_gnt,
  input logic             hold_live
);
  localparam int CPU_BIT = N_DMA + 2;
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_RSV_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(rsv_slot) |-> bus_gnt == '0); // R1
  AST_COP_WINS: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    ($past(cop_req) && !$past(rsv_slot) && !$past(hold_live)) |-> bus_gnt[0]); // R2
  AST_BLT_UNDER_COP: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    bus_gnt[1] |-> !$past(cop_req)); // R3
  AST_CPU_LAST: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    bus_gnt[CPU_BIT] |-> !($past(cop_req) || $past(blt_req) || $past(|dma_req))); // R6
  AST_ONE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_gnt)); // R7
  AST_IDLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle == (bus_gnt == '0)); // R8
  AST_FM_DMA_WINS: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(|fm_dma_req) |-> !fm_gnt[N_DMA]); // R11
  AST_FM_ONE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fm_gnt)); // R11

  for (genvar k = 0; k < N_DMA; k++) begin : g_hold
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_gnt[2+k] && dma_req[k] && !rsv_slot) |=> bus_gnt[2+k]); // R9
  end
endmodule

bind shared_mem_arbiter shared_mem_arbiter_chk #(.N_DMA(N_DMA)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsv_slot(rsv_slot), .cop_req(cop_req),
  .blt_req(blt_req), .dma_req(dma_req), .cpu_req(cpu_req),
  .fm_dma_req(fm_dma_req), .bus_gnt(bus_gnt), .bus_idle(bus_idle),
  .fm_gnt(fm_gnt), .hold_live(hold_live)
);

// File: tb/sim_shared_mem_arbiter.sv
module sim_shared_mem_arbiter;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rsv_slot = 1'b0, cop_req = 1'b0, blt_req = 1'b0, cpu_req = 1'b0, fm_cpu_req = 1'b0;
  logic [N-1:0] dma_req = '0, fm_dma_req = '0;
  logic [N+2:0] bus_gnt;
  logic bus_idle;
  logic [N:0] fm_gnt;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shared_mem_arbiter #(.N_DMA(N)) u0 (
    .clk(clk), .rst_n(rst_n), .rsv_slot(rsv_slot), .cop_req(cop_req),
    .blt_req(blt_req), .dma_req(dma_req), .cpu_req(cpu_req),
    .fm_dma_req(fm_dma_req), .fm_cpu_req(fm_cpu_req),
    .bus_gnt(bus_gnt), .bus_idle(bus_idle), .fm_gnt(fm_gnt)
  );

  // grant vector builders: bit0 cop, bit1 copier, bit 2+k master k, bit N+2 cpu
  function automatic logic [N+2:0] g_dma(input int k);
    logic [N+2:0] v = '0; v[2+k] = 1'b1; return v;
  endfunction
  localparam logic [N+2:0] G_COP = 1, G_BLT = 2, G_CPU = 1 << (N+2), G_NONE = 0;

  task automatic drive(input logic rs, input logic c, input logic b,
                       input logic [N-1:0] d, input logic p);
    @(negedge clk);
    rsv_slot = rs; cop_req = c; blt_req = b; dma_req = d; cpu_req = p;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [N+2:0] exp);
    checks++;
    if (bus_gnt !== exp || bus_idle !== (exp == '0)) begin
      errors++;
      $display("FAIL %s: gnt=%b idle=%b expected gnt=%b idle=%b", req, bus_gnt, bus_idle, exp, exp == '0);
    end
  endtask

  task automatic quiet();
    drive(0, 0, 0, '0, 0);
  endtask

  task automatic t_reset();
    chk("R12", G_NONE);
    checks++;
    if (fm_gnt !== '0) begin errors++; $display("FAIL R12: fm_gnt=%b expected 0", fm_gnt); end
  endtask

  task automatic t_priority();
    drive(0, 1, 1, 4'b1111, 1); chk("R2", G_COP);       quiet();
    drive(0, 0, 1, 4'b0100, 1); chk("R3", G_BLT);       quiet();
    drive(0, 0, 0, 4'b0100, 1); chk("R4", g_dma(2));    quiet();
    drive(0, 0, 0, 4'b0000, 1); chk("R6", G_CPU);       quiet();
    chk("R8", G_NONE);
  endtask

  task automatic t_lowest();
    drive(0, 0, 0, 4'b1010, 1); chk("R5", g_dma(1));
    drive(0, 0, 0, 4'b1000, 1); chk("R5", g_dma(3));
    quiet();
    drive(0, 0, 0, 4'b1100, 0); chk("R5", g_dma(2));
    quiet();
  endtask

  task automatic t_latency();
    @(negedge clk); cop_req = 1'b1;
    #1; chk("R7", G_NONE);
    @(posedge clk); #1; chk("R7", G_COP);
    quiet();
  endtask

  task automatic t_hold();
    drive(0, 0, 0, 4'b0001, 0); chk("R9", g_dma(0));
    drive(0, 1, 1, 4'b0001, 1); chk("R9", g_dma(0));
    drive(0, 1, 0, 4'b0011, 0); chk("R9", g_dma(0));
    drive(0, 1, 0, 4'b0010, 0); chk("R9", G_COP);
    quiet();
  endtask

  task automatic t_reserved();
    drive(1, 1, 1, 4'b1111, 1); chk("R1", G_NONE);
    quiet();
    drive(0, 0, 0, 4'b0100, 0); chk("R10", g_dma(2));
    drive(1, 1, 0, 4'b0110, 0); chk("R1", G_NONE);
    drive(0, 1, 0, 4'b0110, 0); chk("R10", g_dma(2));
    drive(1, 0, 0, 4'b0010, 0); chk("R1", G_NONE);
    drive(0, 1, 0, 4'b0010, 0); chk("R10", G_COP);
    quiet();
  endtask

  task automatic fchk(input logic [N-1:0] d, input logic p, input logic [N:0] exp);
    @(negedge clk); fm_dma_req = d; fm_cpu_req = p;
    @(posedge clk); #1;
    checks++;
    if (fm_gnt !== exp) begin
      errors++;
      $display("FAIL R11: fm_gnt=%b expected %b", fm_gnt, exp);
    end
  endtask

  task automatic t_fast();
    fchk(4'b0110, 1, 5'b00010);
    fchk(4'b1000, 1, 5'b01000);
    fchk(4'b0000, 1, 5'b10000);
    fchk(4'b0000, 0, 5'b00000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; t_reset();
    t_priority();
    t_lowest();
    t_latency();
    t_hold();
    t_reserved();
    t_fast();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule